// File: doc/BRIEF.md
# Compare Timer With Selectable Tick Source

This block is a general-purpose timer with a small 32-bit register interface. An up-counter advances on strobes from one of three tick sources that the control register selects. Each strobe passes through a main divider first. The crystal-derived source also passes through a short divider of its own before it reaches the main one. The counter is `CNT_W` bits wide and is 32 bits by default.

A single compare channel watches the counter. When the counter steps onto the compare value, a sticky match flag sets on the following clock. Software clears the flag by writing a one to it. The flag, gated by an enable bit, drives a level interrupt.

In restart mode the counter returns to zero on the step after a match. In free-running mode it carries on counting. A wait input can freeze all counting unless the control register allows the timer to run during wait.

Top module: `gpt_timer`

## Requirements
- R1: After reset every mapped register reads zero and `irq` is low.
- R2: Control bit 0 enables the timer. While it is clear, the counter reads zero and both dividers restart from zero.
- R3: Control bits 8:6 select the tick source. Code 1 selects `tick_bus` and code 2 selects `tick_per`. Code 5 selects `tick_xtal`, which counts only while control bit 10 is set. Every other code stops counting.
- R4: Prescaler bits 11:0, value N, pass one counter step per N+1 selected ticks. Writing the prescaler register (offset 0x04) restarts both dividers.
- R5: For source code 5, prescaler bits 15:12, value M, pass one tick to the main divider per M+1 gated crystal strobes. The total division is therefore (M+1)(N+1).
- R6: The match flag (status offset 0x08, bit 0) sets on the clock after the counter steps onto the compare value. It is an equality test, so a compare value below the counter matches only after the counter wraps.
- R7: With control bit 9 set, the counter keeps counting past a match. With it clear, the step after a match loads zero.
- R8: Writing 1 to status bit 0 clears the flag, and writing 0 leaves it unchanged. A match in the same cycle as the clear wins.
- R9: `irq` is high exactly while the match flag and interrupt-enable bit 0 (offset 0x0C) are both set.
- R10: While `wait_req` is high and control bit 3 is clear, the counter and dividers freeze. With bit 3 set, counting continues.
- R11: The compare register (offset 0x10) reads back as written. The counter (offset 0x24) is read-only, ignores writes and wraps from all ones to zero.
- R12: Reads of offsets that are not mapped return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte offset of the register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| tick_bus | input | 1 | Bus-clock tick strobe (source code 1) |
| tick_per | input | 1 | Peripheral-clock tick strobe (source code 2) |
| tick_xtal | input | 1 | Crystal-divided tick strobe (source code 5) |
| wait_req | input | 1 | System wait state request |
| irq | output | 1 | Level interrupt |

## Verification
The bench aims at the match timing. A design that set the flag in the same cycle as the step, or on a compare value written equal to a counter that is standing still, would raise `irq` one cycle early or when it should not fire at all. It checks both the restart and the free-running modes, since mixing them up shows as a counter that wraps at the compare value or runs past it. A compare value written behind the counter must stay quiet until the counter wraps, which catches a greater-or-equal comparison. It also checks the cascade of the two dividers, a write of zero to the status register, and a counter write that must be ignored, because off-by-one divider terminals and a writable counter are the usual slips.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_PRE  = 8'h04;
  localparam logic [7:0] OFS_STAT = 8'h08;
  localparam logic [7:0] OFS_IER  = 8'h0C;
  localparam logic [7:0] OFS_CMP  = 8'h10;
  localparam logic [7:0] OFS_CNT  = 8'h24;

  localparam int B_EN    = 0;
  localparam int B_WAIT  = 3;
  localparam int B_SRC   = 6;
  localparam int B_FREE  = 9;
  localparam int B_XGATE = 10;
  localparam int CTRL_W  = 11;
  localparam logic [CTRL_W-1:0] CTRL_MASK = 11'h7C9;

  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_BUS  = 3'd1,
    SRC_PER  = 3'd2,
    SRC_XTAL = 3'd5
  } src_e;

  // One counter step: zero after a match in restart mode, else increment.
  function automatic logic [31:0] count_step(input logic [31:0] cur,
                                             input logic [31:0] cmp,
                                             input logic        free_run);
    return (!free_run && cur == cmp) ? 32'd0 : cur + 32'd1;
  endfunction

  // Divider terminal: the tick that completes a period of limit+1.
  function automatic logic div_last(input logic [15:0] cnt,
                                    input logic [15:0] limit);
    return cnt == limit;
  endfunction
endpackage

// File: rtl/gpt_divider.sv
module gpt_divider #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         tick,
  input  logic [W-1:0] limit,
  output logic         pulse
);
  import gpt_pkg::*;

  logic [W-1:0] cnt_q;

  assign pulse = tick && div_last(16'(cnt_q), 16'(limit));

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt_q <= '0;
    else if (pulse)    cnt_q <= '0;
    else if (tick)     cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/gpt_counter.sv
module gpt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             adv,
  input  logic             free_run,
  input  logic [CNT_W-1:0] cmp,
  output logic [CNT_W-1:0] cnt,
  output logic             hit
);
  import gpt_pkg::*;

  logic [CNT_W-1:0] cnt_q;
  logic             moved_q;

  assign cnt = cnt_q;
  // Match only when the counter has just stepped onto the compare value.
  assign hit = moved_q && (cnt_q == cmp);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      cnt_q   <= '0;
      moved_q <= 1'b0;
    end else begin
      moved_q <= adv;
      if (adv) cnt_q <= CNT_W'(count_step(32'(cnt_q), 32'(cmp), free_run));
    end
  end
endmodule

// File: rtl/gpt_timer.sv
module gpt_timer #(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 32,
  parameter int PDIV_W = 12,
  parameter int XDIV_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              tick_bus,
  input  logic              tick_per,
  input  logic              tick_xtal,
  input  logic              wait_req,
  output logic              irq
);
  import gpt_pkg::*;

  localparam int PRE_W    = PDIV_W + XDIV_W;
  localparam int XDIV_LSB = PDIV_W;

  logic [CTRL_W-1:0] ctrl_q;
  logic [PRE_W-1:0]  pre_q;
  logic              flag_q;
  logic              ier_q;
  logic [CNT_W-1:0]  cmp_q;
  logic [CNT_W-1:0]  cnt_val;

  logic wr_ctrl, wr_pre, wr_stat, wr_ier, wr_cmp;
  assign wr_ctrl = bus_we && bus_addr == ADDR_W'(OFS_CTRL);
  assign wr_pre  = bus_we && bus_addr == ADDR_W'(OFS_PRE);
  assign wr_stat = bus_we && bus_addr == ADDR_W'(OFS_STAT);
  assign wr_ier  = bus_we && bus_addr == ADDR_W'(OFS_IER);
  assign wr_cmp  = bus_we && bus_addr == ADDR_W'(OFS_CMP);

  // Named internal events
  src_e src_sel;
  logic run, div_clr, xtal_tick, xtal_pulse, sel_tick, cnt_adv, cmp_hit;

  assign src_sel   = src_e'(ctrl_q[B_SRC +: 3]);
  assign run       = ctrl_q[B_EN] && (!wait_req || ctrl_q[B_WAIT]);
  assign div_clr   = !ctrl_q[B_EN] || wr_pre;
  assign xtal_tick = run && src_sel == SRC_XTAL && ctrl_q[B_XGATE] && tick_xtal;

  always_comb begin
    unique case (src_sel)
      SRC_BUS:  sel_tick = tick_bus;
      SRC_PER:  sel_tick = tick_per;
      SRC_XTAL: sel_tick = xtal_pulse;
      default:  sel_tick = 1'b0;
    endcase
  end

  gpt_divider #(.W(XDIV_W)) u_xdiv (
    .clk(clk), .rst_n(rst_n), .clr(div_clr), .tick(xtal_tick),
    .limit(pre_q[XDIV_LSB +: XDIV_W]), .pulse(xtal_pulse)
  );

  gpt_divider #(.W(PDIV_W)) u_pdiv (
    .clk(clk), .rst_n(rst_n), .clr(div_clr), .tick(run && sel_tick),
    .limit(pre_q[PDIV_W-1:0]), .pulse(cnt_adv)
  );

  gpt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(ctrl_q[B_EN]), .adv(cnt_adv),
    .free_run(ctrl_q[B_FREE]), .cmp(cmp_q), .cnt(cnt_val), .hit(cmp_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      pre_q  <= '0;
      flag_q <= 1'b0;
      ier_q  <= 1'b0;
      cmp_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= bus_wdata[CTRL_W-1:0] & CTRL_MASK;
      if (wr_pre)  pre_q  <= bus_wdata[PRE_W-1:0];
      if (wr_ier)  ier_q  <= bus_wdata[0];
      if (wr_cmp)  cmp_q  <= bus_wdata[CNT_W-1:0];
      if (cmp_hit)                      flag_q <= 1'b1;
      else if (wr_stat && bus_wdata[0]) flag_q <= 1'b0;
    end
  end

  assign irq = flag_q && ier_q;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(OFS_CTRL): bus_rdata = 32'(ctrl_q);
      ADDR_W'(OFS_PRE):  bus_rdata = 32'(pre_q);
      ADDR_W'(OFS_STAT): bus_rdata = 32'(flag_q);
      ADDR_W'(OFS_IER):  bus_rdata = 32'(ier_q);
      ADDR_W'(OFS_CMP):  bus_rdata = 32'(cmp_q);
      ADDR_W'(OFS_CNT):  bus_rdata = 32'(cnt_val);
      default:           bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpt_timer_chk.sv
module gpt_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             adv,
  input logic             free_run,
  input logic             hit,
  input logic             flag,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cmp
);
  // R2
  off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> cnt == '0);

  // R7
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && adv && !free_run && cnt == cmp |=> cnt == '0);

  // R7
  free_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && adv && free_run |=> cnt == CNT_W'($past(cnt) + 1'b1));

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && !adv |=> $stable(cnt));

  // R6
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag);

  // R8
  flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(hit));
endmodule

bind gpt_timer gpt_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(ctrl_q[0]), .adv(cnt_adv),
  .free_run(ctrl_q[9]), .hit(cmp_hit), .flag(flag_q),
  .cnt(cnt_val), .cmp(cmp_q)
);

// File: tb/sim_gpt_timer.sv
module sim_gpt_timer;
  localparam int CW = 10;
  localparam logic [31:0] MASK = (32'd1 << CW) - 1;

  logic clk = 0, rst_n = 0;
  logic [7:0] bus_addr = 8'h24;
  logic bus_we = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic tick_bus = 0, tick_per = 0, tick_xtal = 0, wait_req = 0, irq;
  int nchk = 0, nfail = 0;
  bit done = 0;
  int tick_mode = 0;

  gpt_timer #(.CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_bus(tick_bus),
    .tick_per(tick_per), .tick_xtal(tick_xtal), .wait_req(wait_req), .irq(irq)
  );

  always #4 clk = ~clk;

  // Behavioural reference
  logic [31:0] m_ctrl = 0, m_pre = 0, m_cmp = 0, m_cnt = 0;
  int unsigned m_pc = 0, m_xc = 0;
  bit m_flag = 0, m_ier = 0, m_moved = 0;
  int unsigned n_pc, n_xc, src;
  logic [31:0] n_cnt;
  bit run, xo, raw, adv, hit;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_pre = 0; m_cmp = 0; m_cnt = 0; m_pc = 0; m_xc = 0;
      m_flag = 0; m_ier = 0; m_moved = 0;
    end else begin
      run = m_ctrl[0] && (!wait_req || m_ctrl[3]);
      src = m_ctrl[8:6];
      xo = 0; n_xc = m_xc;
      if (run && src == 5 && m_ctrl[10] && tick_xtal) begin
        if (m_xc == m_pre[15:12]) begin xo = 1; n_xc = 0; end
        else n_xc = m_xc + 1;
      end
      raw = (src == 1) ? tick_bus : (src == 2) ? tick_per : (src == 5) ? xo : 0;
      adv = 0; n_pc = m_pc;
      if (run && raw) begin
        if (m_pc == m_pre[11:0]) begin adv = 1; n_pc = 0; end
        else n_pc = m_pc + 1;
      end
      hit = m_moved && m_cnt == m_cmp;
      if (!m_ctrl[0]) n_cnt = 0;
      else if (adv) n_cnt = (!m_ctrl[9] && m_cnt == m_cmp) ? 0 : ((m_cnt + 1) & MASK);
      else n_cnt = m_cnt;
      if (!m_ctrl[0] || (bus_we && bus_addr == 8'h04)) begin n_pc = 0; n_xc = 0; end
      m_moved = m_ctrl[0] && adv;
      if (hit) m_flag = 1;
      else if (bus_we && bus_addr == 8'h08 && bus_wdata[0]) m_flag = 0;
      if (bus_we) begin
        case (bus_addr)
          8'h00: m_ctrl = bus_wdata & 32'h7C9;
          8'h04: m_pre  = bus_wdata & 32'hFFFF;
          8'h0C: m_ier  = bus_wdata[0];
          8'h10: m_cmp  = bus_wdata & MASK;
          default: ;
        endcase
      end
      m_cnt = n_cnt; m_pc = n_pc; m_xc = n_xc;
    end
  end

  function automatic logic [31:0] mread(input logic [7:0] a);
    case (a)
      8'h00: return m_ctrl;
      8'h04: return m_pre;
      8'h08: return 32'(m_flag);
      8'h0C: return 32'(m_ier);
      8'h10: return m_cmp;
      8'h24: return m_cnt;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Every-cycle comparison against the reference
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      chk("R9 irq", 32'(irq), 32'(m_flag && m_ier));
      if (bus_addr == 8'h24) chk("R11 counter", bus_rdata, m_cnt);
    end
  end

  always @(negedge clk) begin
    if (tick_mode == 0) begin
      tick_bus = 1; tick_per = 1; tick_xtal = 1;
    end else begin
      tick_bus = 1'($urandom % 2); tick_per = 1'($urandom % 2); tick_xtal = 1'($urandom % 2);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 0; bus_addr = 8'h24;
  endtask

  task automatic rd_model(input logic [7:0] a, input string tag);
    @(negedge clk); bus_addr = a; #1;
    chk(tag, bus_rdata, mread(a));
    bus_addr = 8'h24;
  endtask

  task automatic rd_lit(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); bus_addr = a; #1;
    chk(tag, bus_rdata, exp);
    bus_addr = 8'h24;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset values
    for (int i = 0; i < 6; i++) rd_lit(8'(i == 5 ? 8'h24 : i * 4), 0, "R1 reset reg");
    chk("R1 irq", 32'(irq), 0);

    // Restart mode, full-rate bus ticks
    wr(8'h0C, 1); wr(8'h10, 5); wr(8'h00, 32'h041);
    repeat (12) @(negedge clk);
    rd_model(8'h08, "R6 flag");
    rd_model(8'h24, "R7 restart cnt");
    // Code 0 stops counting; flag sticky
    wr(8'h00, 32'h001);
    repeat (3) @(negedge clk);
    rd_model(8'h24, "R3 code0 hold");
    rd_lit(8'h08, 1, "R8 flag set");
    wr(8'h08, 0);
    rd_lit(8'h08, 1, "R8 write0 ignored");
    chk("R9 irq high", 32'(irq), 1);
    wr(8'h0C, 0);
    chk("R9 irq masked", 32'(irq), 0);
    wr(8'h08, 1);
    rd_lit(8'h08, 0, "R8 w1c");
    wr(8'h0C, 1);

    // Free-running
    wr(8'h00, 32'h241);
    repeat (20) @(negedge clk);
    rd_model(8'h24, "R7 free run");

    // Main prescaler, peripheral source, random ticks
    wr(8'h04, 3); wr(8'h00, 32'h081); tick_mode = 1;
    repeat (60) @(negedge clk);
    rd_model(8'h24, "R4 prescale");
    rd_model(8'h04, "R4 pre reg");

    // Crystal source: gate off, then cascade
    tick_mode = 0;
    wr(8'h00, 32'h141);
    repeat (10) @(negedge clk);
    rd_model(8'h24, "R3 gate off");
    wr(8'h04, 32'h7001); wr(8'h00, 32'h541);
    repeat (80) @(negedge clk);
    rd_model(8'h24, "R5 cascade");

    // Wait mode
    wr(8'h04, 0); wr(8'h00, 32'h241);
    wait_req = 1;
    repeat (10) @(negedge clk);
    rd_model(8'h24, "R10 frozen");
    wr(8'h00, 32'h249);
    repeat (10) @(negedge clk);
    rd_model(8'h24, "R10 runs");
    wait_req = 0;

    // Register access
    wr(8'h24, 32'h3FF);
    rd_model(8'h24, "R11 ro counter");
    wr(8'h10, 32'h123);
    rd_lit(8'h10, 32'h123, "R11 cmp rw");
    rd_lit(8'h18, 0, "R12 unmapped");
    rd_lit(8'h40, 0, "R12 unmapped");

    // Compare behind the counter: quiet until wrap
    wr(8'h00, 32'h201);
    wr(8'h10, (m_cnt - 2) & MASK);
    wr(8'h08, 1);
    wr(8'h00, 32'h241);
    repeat (20) @(negedge clk);
    rd_lit(8'h08, 0, "R6 behind no match");
    repeat (1100) @(negedge clk);
    rd_lit(8'h08, 1, "R6 match after wrap");

    // Disable
    wr(8'h00, 0);
    repeat (2) @(negedge clk);
    rd_lit(8'h24, 0, "R2 disabled zero");
    finish_run();
  end
endmodule